// File: doc/BRIEF.md
# Multi-channel PS/2 host transmitter

This block sends one byte from a host controller to a PS/2 device. Four clock/data line pairs are attached, and one serial shifter is shared among them. The enable vector picks the channel, and the lowest set bit wins. Every line is open-drain. For each line the block has a drive-low output, and it reads back the line level through a two-flop synchronizer. After a write to the transmit data port, the block pulls the chosen data line low as the start bit and leaves the clock free. From then on the device generates the clock, and the block changes the data line once after each falling edge: eight data bits LSB first, an odd parity bit and a stop bit.

After the eleventh falling edge the block samples the data line, where the device answers. A low level is an acknowledge. On an acknowledge the block enters its end-of-transmission state, sets a sticky completion flag, and can raise an interrupt. In that state it pulls every clock line low and releases every data line, and only a reset brings it out. A high level where the acknowledge should be sets an error flag and returns the shifter to idle. Clearing every channel enable during a transfer abandons it and releases all lines.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset no clock or data line is pulled low, busy is 0, and both status flags and the interrupt are 0.
- R2: A pulse on tx_wr while idle with at least one enable bit set starts a transfer. From the next cycle busy is 1 and only the data line of the lowest enabled channel is pulled low as the start bit, with all clocks released.
- R3: After synchronized falling edges 1 to 8 of the active channel's clock, the data line carries data bits 0 to 7 in turn. A 0 bit is shown by pulling the line low.
- R4: After falling edge 9 the data line carries odd parity: released (1) when the byte has an even number of ones, pulled low otherwise.
- R5: After falling edge 10 the data line is released (stop bit 1) and stays released so the device can answer.
- R6: A low data line sampled at falling edge 11 enters end-of-transmission. All four clock lines are pulled low, all data lines are released, busy drops, and eot_flag becomes 1.
- R7: irq is 1 exactly when eot_flag is 1 and irq_en is 1.
- R8: Once in end-of-transmission, the block ignores writes, enable changes and clock edges, and holds every clock low until reset.
- R9: Clearing all enable bits at any point of a transfer returns the block to idle with all lines released and no flag set. A later write starts a fresh transfer.
- R10: A high data line sampled at falling edge 11 sets err_flag and leaves eot_flag at 0, with the block idle and all lines released.
- R11: A pulse on eot_clr clears eot_flag (and so irq), and a pulse on err_clr clears err_flag. Clearing the flag does not release the clocks held in end-of-transmission.
- R12: A tx_wr pulse while a transfer is running, or while no enable bit is set, has no effect on the lines or on the byte being sent.
- R13: Only the active channel's data line is ever pulled low during a transfer, and falling edges on any other channel's clock do not advance the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 4 | Channel enables; lowest set bit selects the channel, all clear aborts |
| irq_en | input | 1 | Interrupt enable for completion |
| tx_wr | input | 1 | Write strobe for tx_data; starts a transfer when idle |
| tx_data | input | 8 | Byte to send |
| eot_clr | input | 1 | Write-one-to-clear pulse for eot_flag |
| err_clr | input | 1 | Write-one-to-clear pulse for err_flag |
| ps2_clk_in | input | 4 | Raw clock line levels, one per channel |
| ps2_dat_in | input | 4 | Raw data line levels, one per channel |
| ps2_clk_oe | output | 4 | Pull clock line low, one per channel |
| ps2_dat_oe | output | 4 | Pull data line low, one per channel |
| busy | output | 1 | Transfer in progress |
| eot_flag | output | 1 | Sticky completion flag |
| err_flag | output | 1 | Sticky missing-acknowledge flag |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach is an abort at a chosen bit position. The bench models each line as a wired-AND of the device drive and the block's pull. It then runs a device model that produces exactly the requested number of clock edges and clears the enables between two edges, once for every position from the start bit to the stop bit. A sweep over all 256 byte values rotates through the channels and enable patterns, and checks every bit after every edge. Some iterations add a write during a running transfer, or edges on a foreign channel, or activity after completion.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    localparam int PS2_NCH    = 4;
    localparam int PS2_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic ack_ok;
        logic ack_missing;
    } tx_evt_t;

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] clk_raw,
    input  logic [NCH-1:0] dat_raw,
    output logic [NCH-1:0] dat_s,
    output logic [NCH-1:0] clk_fall
);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic c1, c2, c3, d1, d2;
        always_ff @(posedge clk) begin
            if (rst) begin
                c1 <= 1'b1;
                c2 <= 1'b1;
                c3 <= 1'b1;
                d1 <= 1'b1;
                d2 <= 1'b1;
            end else begin
                c1 <= clk_raw[c];
                c2 <= c1;
                c3 <= c2;
                d1 <= dat_raw[c];
                d2 <= d1;
            end
        end
        assign clk_fall[c] = c3 & ~c2;
        assign dat_s[c]    = d2;
    end

endmodule

// File: rtl/ps2tx_shifter.sv
module ps2tx_shifter
    import ps2tx_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CW  = $clog2(DW + 4)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] chan_en,
    input  logic           tx_wr,
    input  logic [DW-1:0]  tx_data,
    input  logic [NCH-1:0] clk_fall,
    input  logic [NCH-1:0] dat_s,
    output tx_state_e      state,
    output logic [CHW-1:0] act_ch,
    output logic           pull_low,
    output tx_evt_t        evt
);

    localparam logic [CW-1:0] LAST_DATA = CW'(DW);
    localparam logic [CW-1:0] STOP_IDX  = CW'(DW + 1);
    localparam logic [CW-1:0] ACK_IDX   = CW'(DW + 2);

    logic [CW-1:0]  edge_cnt;
    logic [DW-1:0]  shreg;
    logic           par_bit;
    logic [CHW-1:0] sel;
    logic           any_en;
    logic           fall_act;
    logic           ack_edge;

    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (chan_en[i]) sel = CHW'(i);
        end
    end

    assign any_en   = |chan_en;
    assign fall_act = clk_fall[act_ch];
    assign ack_edge = (state == ST_SHIFT) && any_en && fall_act && (edge_cnt == ACK_IDX);

    assign evt.ack_ok      = ack_edge && !dat_s[act_ch];
    assign evt.ack_missing = ack_edge &&  dat_s[act_ch];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            act_ch   <= '0;
            edge_cnt <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            pull_low <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (tx_wr && any_en) begin
                        state    <= ST_SHIFT;
                        act_ch   <= sel;
                        shreg    <= tx_data;
                        par_bit  <= ~^tx_data;
                        edge_cnt <= '0;
                        pull_low <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (!any_en) begin
                        state    <= ST_IDLE;
                        pull_low <= 1'b0;
                    end else if (fall_act) begin
                        edge_cnt <= edge_cnt + 1'b1;
                        if (edge_cnt < LAST_DATA) begin
                            pull_low <= ~shreg[0];
                            shreg    <= shreg >> 1;
                        end else if (edge_cnt == LAST_DATA) begin
                            pull_low <= ~par_bit;
                        end else if (edge_cnt == STOP_IDX) begin
                            pull_low <= 1'b0;
                        end else begin
                            pull_low <= 1'b0;
                            state    <= dat_s[act_ch] ? ST_IDLE : ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && tx_wr && any_en) |=> (state == ST_SHIFT && pull_low));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT) |-> (edge_cnt <= ACK_IDX));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_DONE));

    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && !any_en) |=> (state == ST_IDLE && !pull_low));

    p_idle_wr_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && tx_wr && any_en && !fall_act) |=> $stable(shreg));

endmodule

// File: rtl/ps2tx_flags.sv
module ps2tx_flags
    import ps2tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tx_evt_t evt,
    input  logic    eot_clr,
    input  logic    err_clr,
    input  logic    irq_en,
    output logic    eot_flag,
    output logic    err_flag,
    output logic    irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            eot_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (evt.ack_ok)          eot_flag <= 1'b1;
            else if (eot_clr)        eot_flag <= 1'b0;
            if (evt.ack_missing)     err_flag <= 1'b1;
            else if (err_clr)        err_flag <= 1'b0;
        end
    end

    assign irq = eot_flag & irq_en;

    p_eot_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (eot_flag && !eot_clr) |=> eot_flag);

    p_eot_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (eot_clr && !evt.ack_ok) |=> !eot_flag);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag);

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
    import ps2tx_pkg::*;
#(
    parameter int NCH = ps2tx_pkg::PS2_NCH,
    parameter int DW  = ps2tx_pkg::PS2_DATA_W,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] chan_en,
    input  logic           irq_en,
    input  logic           tx_wr,
    input  logic [DW-1:0]  tx_data,
    input  logic           eot_clr,
    input  logic           err_clr,
    input  logic [NCH-1:0] ps2_clk_in,
    input  logic [NCH-1:0] ps2_dat_in,
    output logic [NCH-1:0] ps2_clk_oe,
    output logic [NCH-1:0] ps2_dat_oe,
    output logic           busy,
    output logic           eot_flag,
    output logic           err_flag,
    output logic           irq
);

    logic [NCH-1:0] dat_s;
    logic [NCH-1:0] clk_fall;
    tx_state_e      state;
    logic [CHW-1:0] act_ch;
    logic           pull_low;
    tx_evt_t        evt;

    ps2tx_sync #(.NCH(NCH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .clk_raw  (ps2_clk_in),
        .dat_raw  (ps2_dat_in),
        .dat_s    (dat_s),
        .clk_fall (clk_fall)
    );

    ps2tx_shifter #(.NCH(NCH), .DW(DW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .chan_en  (chan_en),
        .tx_wr    (tx_wr),
        .tx_data  (tx_data),
        .clk_fall (clk_fall),
        .dat_s    (dat_s),
        .state    (state),
        .act_ch   (act_ch),
        .pull_low (pull_low),
        .evt      (evt)
    );

    ps2tx_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .eot_clr  (eot_clr),
        .err_clr  (err_clr),
        .irq_en   (irq_en),
        .eot_flag (eot_flag),
        .err_flag (err_flag),
        .irq      (irq)
    );

    assign busy       = (state == ST_SHIFT);
    assign ps2_clk_oe = {NCH{state == ST_DONE}};
    assign ps2_dat_oe = (busy && pull_low) ? (NCH'(1) << act_ch) : '0;

    p_dat_onehot_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ps2_dat_oe));

    p_eot_clamp_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(eot_flag) |-> (&ps2_clk_oe && ps2_dat_oe == '0 && !busy));

    p_err_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> (!busy && ps2_clk_oe == '0 && ps2_dat_oe == '0));

    p_irq_needs_eot_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> eot_flag);

endmodule

// File: tb/tb_ps2_host_tx.sv
module tb_ps2_host_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] chan_en = 4'h0;
    logic       irq_en = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       eot_clr = 1'b0;
    logic       err_clr = 1'b0;
    logic [3:0] dev_clk = 4'hF;
    logic [3:0] dev_dat = 4'hF;
    logic [3:0] ps2_clk_in, ps2_dat_in, ps2_clk_oe, ps2_dat_oe;
    logic       busy, eot_flag, err_flag, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign ps2_clk_in = dev_clk & ~ps2_clk_oe;
    assign ps2_dat_in = dev_dat & ~ps2_dat_oe;

    ps2_host_tx dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .irq_en(irq_en),
        .tx_wr(tx_wr), .tx_data(tx_data), .eot_clr(eot_clr), .err_clr(err_clr),
        .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
        .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
        .busy(busy), .eot_flag(eot_flag), .err_flag(err_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; dev_clk = 4'hF; dev_dat = 4'hF; tx_wr = 1'b0;
        eot_clr = 1'b0; err_clr = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(2);
    endtask

    task automatic write_byte(input logic [7:0] b);
        tx_data = b; tx_wr = 1'b1;
        tick(1);
        tx_wr = 1'b0;
        tick(1);
    endtask

    task automatic fall(input int c);
        dev_clk[c] = 1'b0;
        tick(6);
    endtask

    task automatic rise(input int c);
        dev_clk[c] = 1'b1;
        tick(6);
    endtask

    function automatic logic exp_low(input logic [7:0] b, input int k);
        if (k == 0)      return 1'b1;
        else if (k <= 8) return ~b[k-1];
        else if (k == 9) return ^b;
        else             return 1'b0;
    endfunction

    task automatic expect_line(input int c, input logic low, input string tag);
        logic [3:0] exp_d;
        exp_d = low ? 4'(1 << c) : 4'h0;
        chk(ps2_dat_oe == exp_d && ps2_clk_oe == 4'h0, tag,
            {ps2_clk_oe, ps2_dat_oe}, {4'h0, exp_d});
    endtask

    function automatic string tag_for(input int k);
        if (k <= 8)      return "R3 data bit";
        else if (k == 9) return "R4 parity";
        else             return "R5 stop";
    endfunction

    task automatic run_one(input int b);
        logic [7:0] bv;
        int c, o;
        bv = 8'(b);
        c  = b % 4;
        o  = (c + 1) % 4;
        do_reset();
        if (b == 0) begin
            chk(ps2_clk_oe == 0 && ps2_dat_oe == 0 && !busy, "R1 lines idle",
                {ps2_clk_oe, ps2_dat_oe, 3'b0, busy}, 0);
            chk(!eot_flag && !err_flag && !irq, "R1 flags clear",
                {eot_flag, err_flag, irq}, 0);
        end
        chan_en = 4'hF << c;
        irq_en  = bv[0];
        tick(1);
        write_byte(bv);
        chk(busy == 1'b1, "R2 busy after write", busy, 1);
        expect_line(c, 1'b1, "R2 start bit");
        for (int k = 1; k <= 10; k++) begin
            fall(c);
            if (b % 8 == 3 && k == 3) write_byte(~bv); // R12 write while busy
            expect_line(c, exp_low(bv, k), tag_for(k));
            if (b % 8 == 5 && k == 4) begin
                fall(o); rise(o);
                expect_line(c, exp_low(bv, k), "R13 foreign edge ignored");
            end
            rise(c);
        end
        dev_dat[c] = 1'b0;
        tick(4);
        fall(c);
        chk(ps2_clk_oe == 4'hF && ps2_dat_oe == 4'h0 && !busy, "R6 clocks clamped",
            {ps2_clk_oe, ps2_dat_oe}, 8'hF0);
        chk(eot_flag == 1'b1 && err_flag == 1'b0, "R6 eot flag", {eot_flag, err_flag}, 2);
        chk(irq == bv[0], "R7 irq follows enable", irq, bv[0]);
        dev_dat[c] = 1'b1;
        rise(c);
        if (b % 16 == 7) begin
            irq_en = 1'b1; tick(1);
            chk(irq == 1'b1, "R7 irq on enable", irq, 1);
            write_byte(8'h3C);
            fall(c); rise(c);
            chan_en = 4'h0; tick(3);
            chan_en = 4'h2; tick(3);
            chk(ps2_clk_oe == 4'hF && ps2_dat_oe == 0 && !busy && eot_flag,
                "R8 done state held", {ps2_clk_oe, ps2_dat_oe}, 8'hF0);
            eot_clr = 1'b1; tick(1); eot_clr = 1'b0; tick(1);
            chk(!eot_flag && !irq, "R11 eot cleared", {eot_flag, irq}, 0);
            chk(ps2_clk_oe == 4'hF, "R11 clocks still clamped", ps2_clk_oe, 15);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < 256; b++) run_one(b);

        // R9: abort at every position from start bit to stop bit
        for (int e = 0; e <= 10; e++) begin
            int c;
            c = e % 4;
            do_reset();
            chan_en = 4'(1 << c); irq_en = 1'b1; tick(1);
            write_byte(8'h5A);
            for (int k = 1; k <= e; k++) begin fall(c); rise(c); end
            chan_en = 4'h0; tick(2);
            chk(!busy && ps2_dat_oe == 0 && ps2_clk_oe == 0, "R9 abort releases",
                {ps2_clk_oe, ps2_dat_oe, 3'b0, busy}, 0);
            chk(!eot_flag && !err_flag, "R9 abort no flag", {eot_flag, err_flag}, 0);
            chan_en = 4'(1 << c); tick(1);
            write_byte(8'hC3);
            expect_line(c, 1'b1, "R9 fresh start bit");
            fall(c);
            expect_line(c, exp_low(8'hC3, 1), "R9 fresh bit 0");
            rise(c);
        end

        // R12: write with no enable set
        do_reset();
        chan_en = 4'h0; tick(1);
        write_byte(8'h00);
        chk(!busy && ps2_dat_oe == 0, "R12 write without enable", {3'b0, busy}, 0);

        // R10: missing acknowledge
        do_reset();
        chan_en = 4'h8; irq_en = 1'b1; tick(1);
        write_byte(8'h96);
        for (int k = 1; k <= 10; k++) begin fall(3); rise(3); end
        fall(3);
        chk(err_flag && !eot_flag && !irq, "R10 missing ack flags",
            {eot_flag, err_flag, irq}, 2);
        chk(!busy && ps2_clk_oe == 0 && ps2_dat_oe == 0, "R10 idle after error",
            {ps2_clk_oe, ps2_dat_oe}, 0);
        rise(3);
        err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
        chk(!err_flag, "R11 err cleared", err_flag, 0);
        write_byte(8'h01);
        for (int k = 1; k <= 10; k++) begin fall(3); rise(3); end
        dev_dat[3] = 1'b0; tick(4); fall(3);
        chk(eot_flag && ps2_clk_oe == 4'hF, "R10 recovery to done", eot_flag, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule